// File: doc/BRIEF.md
# Dual-Array Peak Cross-Metric Selector

This block picks the best of several candidate delays. Each delay supplies two arrays of unsigned energy values, called x and y, of equal length. Both arrays arrive together, one element of each per accepted cycle. For every delay the block finds the largest value in each array and the position of that value. It then builds a score for the delay. The score measures how far each peak stands above the other array's value at the same position. Over a frame of delays it keeps the delay with the highest score. It reports that delay, the two peak positions belonging to it, and the score.

A frame opens with a one-cycle start strobe. The delays then follow in order, and each one ends with a last flag on its final element. Delays may follow each other with no idle cycle between them, and the valid input may drop in the middle of a delay. After the final delay has been compared, a one-cycle done pulse marks the outputs as valid for that frame.

Top module: `peak_cross_selector`

## Requirements
- R1: After reset, done is 0 and best_score, best_delay, bin_lo and bin_hi are all 0.
- R2: For each delay, bin_lo candidate is the position of the largest x element and bin_hi candidate is the position of the largest y element. Positions count from 0 for the first accepted element of the delay. When equal maxima occur, the smallest position is taken.
- R3: The score of a delay is (xpk − x[ypos]) + (ypk − y[xpos]). Here xpk and xpos are the peak value and position of x, and ypk and ypos are those of y.
- R4: Inputs are ELEM_W-bit unsigned integers (default 7). The score is ELEM_W+1 bits, so the worst case of 2·(2^ELEM_W − 1), which is 254 by default, is reported without overflow.
- R5: The reported delay is the one with the largest score in the frame. When scores tie, the lowest delay index wins. bin_lo, bin_hi and best_score come from that delay.
- R6: A frame_start pulse clears best_score and best_delay to 0 and restarts delay numbering at 0, so the first delay after it is delay 0.
- R7: done is a one-cycle pulse. It is high in the cycle that begins at the second rising edge after the edge that accepts the last element of delay N_DELAY−1. At that time the outputs already hold the frame result.
- R8: A delay may start in the cycle right after the previous delay's last element, and in_valid may be low for any number of cycles inside a delay. Neither changes any result.
- R9: After done, best_delay, bin_lo, bin_hi and best_score hold their values until new scores arrive or frame_start is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that opens a frame |
| in_valid | input | 1 | x_in and y_in carry an element this cycle |
| in_last | input | 1 | With in_valid, marks the last element of a delay |
| x_in | input | ELEM_W | Element of array x |
| y_in | input | ELEM_W | Element of array y |
| done | output | 1 | Frame result is ready (one-cycle pulse) |
| best_delay | output | $clog2(N_DELAY) | Index of the winning delay |
| bin_lo | output | $clog2(N_ELEM) | Peak position of x for the winning delay |
| bin_hi | output | $clog2(N_ELEM) | Peak position of y for the winning delay |
| best_score | output | ELEM_W+1 | Score of the winning delay |

## Verification
The assertions rely on a few conditions on the inputs:
- frame_start never arrives in the same cycle as in_valid, or while a delay's score is still in flight.
- Every delay delivers exactly N_ELEM elements, and in_last marks the final one.

Under these conditions the peak register only grows within a delay, and the best score only grows after delay 0. The stimulus respects them by design: the driver task always sends whole delays of fixed length and pulses frame_start only while the stream is idle. Valid gaps are placed only between elements, never in place of in_last.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  parameter int unsigned PCS_ELEM_W  = 7;
  parameter int unsigned PCS_N_ELEM  = 8;
  parameter int unsigned PCS_N_DELAY = 8;

  // Candidate replaces the running peak only if strictly larger,
  // or if it is the first element of the array (lowest index wins ties).
  function automatic logic takes_peak(input int unsigned cand,
                                      input int unsigned cur,
                                      input logic        first);
    return first || (cand > cur);
  endfunction
endpackage

// File: rtl/pcs_peak_track.sv
module pcs_peak_track #(
  parameter int unsigned W  = 7,
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data,
  output logic [W-1:0]  peak_val,
  output logic [IW-1:0] peak_idx
);
  import pcs_pkg::*;

  logic [W-1:0]  mem_q [N];
  logic [W-1:0]  pk_val_q, pk_val_d;
  logic [IW-1:0] pk_idx_q, pk_idx_d;
  logic          upd;

  // element buffer: one enable per entry
  for (genvar g = 0; g < N; g++) begin : g_ent
    logic ent_en;
    assign ent_en = wr_en && (wr_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (ent_en) mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_idx];

  always_comb begin
    upd      = wr_en && takes_peak(int'(wr_data), int'(pk_val_q), wr_idx == '0);
    pk_val_d = pk_val_q;
    pk_idx_d = pk_idx_q;
    if (upd) begin
      pk_val_d = wr_data;
      pk_idx_d = wr_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pk_val_q <= '0;
      pk_idx_q <= '0;
    end else begin
      pk_val_q <= pk_val_d;
      pk_idx_q <= pk_idx_d;
    end
  end

  assign peak_val = pk_val_q;
  assign peak_idx = pk_idx_q;
endmodule

// File: rtl/pcs_score_unit.sv
module pcs_score_unit #(
  parameter int unsigned W  = 7,
  parameter int unsigned IW = 3,
  parameter int unsigned DW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [DW-1:0] go_dly,
  input  logic [W-1:0]  x_pk,
  input  logic [IW-1:0] x_pos,
  input  logic [W-1:0]  x_at_ypos,
  input  logic [W-1:0]  y_pk,
  input  logic [IW-1:0] y_pos,
  input  logic [W-1:0]  y_at_xpos,
  output logic          sc_vld,
  output logic [DW-1:0] sc_dly,
  output logic [IW-1:0] sc_lo,
  output logic [IW-1:0] sc_hi,
  output logic [W:0]    sc_val
);
  logic [W-1:0] dx, dy;
  logic [W:0]   sum_d;

  always_comb begin
    dx    = x_pk - x_at_ypos;
    dy    = y_pk - y_at_xpos;
    sum_d = {1'b0, dx} + {1'b0, dy};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sc_vld <= 1'b0;
      sc_dly <= '0;
      sc_lo  <= '0;
      sc_hi  <= '0;
      sc_val <= '0;
    end else begin
      sc_vld <= go;
      if (go) begin
        sc_dly <= go_dly;
        sc_lo  <= x_pos;
        sc_hi  <= y_pos;
        sc_val <= sum_d;
      end
    end
  end
endmodule

// File: rtl/pcs_best_keep.sv
module pcs_best_keep #(
  parameter int unsigned W   = 7,
  parameter int unsigned IW  = 3,
  parameter int unsigned DW  = 3,
  parameter int unsigned NDL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sc_vld,
  input  logic [DW-1:0] sc_dly,
  input  logic [IW-1:0] sc_lo,
  input  logic [IW-1:0] sc_hi,
  input  logic [W:0]    sc_val,
  output logic          done,
  output logic [DW-1:0] bst_dly,
  output logic [IW-1:0] bst_lo,
  output logic [IW-1:0] bst_hi,
  output logic [W:0]    bst_val
);
  localparam logic [DW-1:0] FINAL_DLY = DW'(NDL - 1);

  logic          take, done_d;
  logic [DW-1:0] dly_d;
  logic [IW-1:0] lo_d, hi_d;
  logic [W:0]    val_d;

  always_comb begin
    take   = sc_vld && ((sc_dly == '0) || (sc_val > bst_val));
    done_d = sc_vld && (sc_dly == FINAL_DLY) && !clr;
    dly_d  = bst_dly;
    lo_d   = bst_lo;
    hi_d   = bst_hi;
    val_d  = bst_val;
    if (clr) begin
      dly_d = '0;
      lo_d  = '0;
      hi_d  = '0;
      val_d = '0;
    end else if (take) begin
      dly_d = sc_dly;
      lo_d  = sc_lo;
      hi_d  = sc_hi;
      val_d = sc_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done    <= 1'b0;
      bst_dly <= '0;
      bst_lo  <= '0;
      bst_hi  <= '0;
      bst_val <= '0;
    end else begin
      done    <= done_d;
      bst_dly <= dly_d;
      bst_lo  <= lo_d;
      bst_hi  <= hi_d;
      bst_val <= val_d;
    end
  end
endmodule

// File: rtl/peak_cross_selector.sv
module peak_cross_selector #(
  parameter int unsigned ELEM_W  = pcs_pkg::PCS_ELEM_W,
  parameter int unsigned N_ELEM  = pcs_pkg::PCS_N_ELEM,
  parameter int unsigned N_DELAY = pcs_pkg::PCS_N_DELAY,
  localparam int unsigned IDX_W  = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned DLY_W  = (N_DELAY > 1) ? $clog2(N_DELAY) : 1,
  localparam int unsigned SCORE_W = ELEM_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [ELEM_W-1:0]  x_in,
  input  logic [ELEM_W-1:0]  y_in,
  output logic               done,
  output logic [DLY_W-1:0]   best_delay,
  output logic [IDX_W-1:0]   bin_lo,
  output logic [IDX_W-1:0]   bin_hi,
  output logic [SCORE_W-1:0] best_score
);
  localparam logic [DLY_W-1:0] LAST_DLY = DLY_W'(N_DELAY - 1);

  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DLY_W-1:0]  dly_q, dly_d;
  logic              pend_q, pend_d;
  logic [DLY_W-1:0]  pend_dly_q;
  logic              acc_last;

  logic [ELEM_W-1:0] x_peak, y_peak, x_rd, y_rd;
  logic [IDX_W-1:0]  x_pos, y_pos;

  logic               s_vld;
  logic [DLY_W-1:0]   s_dly;
  logic [IDX_W-1:0]   s_lo, s_hi;
  logic [SCORE_W-1:0] s_score;

  always_comb begin
    acc_last = in_valid && in_last && !frame_start;
    idx_d    = idx_q;
    dly_d    = dly_q;
    if (frame_start) begin
      idx_d = '0;
      dly_d = '0;
    end else if (in_valid) begin
      idx_d = in_last ? '0 : idx_q + 1'b1;
      if (in_last) dly_d = (dly_q == LAST_DLY) ? '0 : dly_q + 1'b1;
    end
    pend_d = acc_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q      <= '0;
      dly_q      <= '0;
      pend_q     <= 1'b0;
      pend_dly_q <= '0;
    end else begin
      idx_q  <= idx_d;
      dly_q  <= dly_d;
      pend_q <= pend_d;
      if (acc_last) pend_dly_q <= dly_q;
    end
  end

  pcs_peak_track #(.W(ELEM_W), .N(N_ELEM), .IW(IDX_W)) u_x_trk (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid && !frame_start),
    .wr_idx(idx_q), .wr_data(x_in), .rd_idx(y_pos), .rd_data(x_rd),
    .peak_val(x_peak), .peak_idx(x_pos)
  );

  pcs_peak_track #(.W(ELEM_W), .N(N_ELEM), .IW(IDX_W)) u_y_trk (
    .clk(clk), .rst_n(rst_n), .wr_en(in_valid && !frame_start),
    .wr_idx(idx_q), .wr_data(y_in), .rd_idx(x_pos), .rd_data(y_rd),
    .peak_val(y_peak), .peak_idx(y_pos)
  );

  pcs_score_unit #(.W(ELEM_W), .IW(IDX_W), .DW(DLY_W)) u_score (
    .clk(clk), .rst_n(rst_n), .go(pend_q), .go_dly(pend_dly_q),
    .x_pk(x_peak), .x_pos(x_pos), .x_at_ypos(x_rd),
    .y_pk(y_peak), .y_pos(y_pos), .y_at_xpos(y_rd),
    .sc_vld(s_vld), .sc_dly(s_dly), .sc_lo(s_lo), .sc_hi(s_hi), .sc_val(s_score)
  );

  pcs_best_keep #(.W(ELEM_W), .IW(IDX_W), .DW(DLY_W), .NDL(N_DELAY)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(frame_start),
    .sc_vld(s_vld), .sc_dly(s_dly), .sc_lo(s_lo), .sc_hi(s_hi), .sc_val(s_score),
    .done(done), .bst_dly(best_delay), .bst_lo(bin_lo), .bst_hi(bin_hi),
    .bst_val(best_score)
  );
endmodule

// File: rtl/pcs_chk.sv
module pcs_chk #(
  parameter int unsigned ELEM_W  = 7,
  parameter int unsigned N_DELAY = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned DLY_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              in_valid,
  input logic              in_last,
  input logic              done,
  input logic [DLY_W-1:0]  best_delay,
  input logic [ELEM_W:0]   best_score,
  input logic              s_vld,
  input logic [DLY_W-1:0]  s_dly,
  input logic [ELEM_W:0]   s_score,
  input logic [IDX_W-1:0]  idx_q,
  input logic [ELEM_W-1:0] x_peak
);
  localparam int unsigned MAX_SCORE = 2 * ((1 << ELEM_W) - 1);

  // R6
  frame_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (best_score == '0 && best_delay == '0));

  // R7
  score_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && !frame_start) |=> ##1 s_vld);

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(s_vld) && $past(s_dly) == DLY_W'(N_DELAY - 1)));

  // R5
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_vld && s_dly != '0 && !frame_start) |=> best_score >= $past(best_score));

  // R2
  peak_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && idx_q != '0 && !frame_start) |=> x_peak >= $past(x_peak));

  // R4
  score_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_vld |-> int'(s_score) <= MAX_SCORE);
endmodule

bind peak_cross_selector pcs_chk #(
  .ELEM_W(ELEM_W), .N_DELAY(N_DELAY), .IDX_W(IDX_W), .DLY_W(DLY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
  .in_last(in_last), .done(done), .best_delay(best_delay),
  .best_score(best_score), .s_vld(s_vld), .s_dly(s_dly), .s_score(s_score),
  .idx_q(idx_q), .x_peak(x_peak)
);

// File: tb/tb_peak_cross_selector.sv
module tb_peak_cross_selector;
  localparam int CLK_PERIOD = 10;
  localparam int EW = 7;
  localparam int NE = 8;
  localparam int ND = 8;
  localparam int IW = 3;
  localparam int DW = 3;

  typedef struct {
    int dly; int lo; int hi; int score; int cyc;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic frame_start, in_valid, in_last;
  logic [EW-1:0] x_in, y_in;
  logic done;
  logic [DW-1:0] best_delay;
  logic [IW-1:0] bin_lo, bin_hi;
  logic [EW:0] best_score;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int xs [ND][NE];
  int ys [ND][NE];
  exp_t exp_q[$];
  exp_t last_exp;

  peak_cross_selector dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .in_valid(in_valid),
    .in_last(in_last), .x_in(x_in), .y_in(y_in), .done(done),
    .best_delay(best_delay), .bin_lo(bin_lo), .bin_hi(bin_hi),
    .best_score(best_score)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model of the requirements
  function automatic exp_t model();
    exp_t e;
    e.dly = 0; e.lo = 0; e.hi = 0; e.score = 0; e.cyc = 0;
    for (int d = 0; d < ND; d++) begin
      int xm, xp, ym, yp, r;
      xm = xs[d][0]; xp = 0; ym = ys[d][0]; yp = 0;
      for (int k = 1; k < NE; k++) begin
        if (xs[d][k] > xm) begin xm = xs[d][k]; xp = k; end
        if (ys[d][k] > ym) begin ym = ys[d][k]; yp = k; end
      end
      r = (xm - xs[d][yp]) + (ym - ys[d][xp]);
      if (d == 0 || r > e.score) begin
        e.dly = d; e.lo = xp; e.hi = yp; e.score = r;
      end
    end
    return e;
  endfunction

  // driver: streams a frame and pushes the expected result
  task automatic run_frame(input bit gaps);
    exp_t e;
    e = model();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int d = 0; d < ND; d++) begin
      for (int k = 0; k < NE; k++) begin
        if (gaps && ($urandom % 3 == 0)) begin
          in_valid = 1'b0;
          @(negedge clk);
        end
        in_valid = 1'b1;
        in_last  = (k == NE - 1);
        x_in     = EW'(xs[d][k]);
        y_in     = EW'(ys[d][k]);
        if (d == ND - 1 && k == NE - 1) begin
          e.cyc = cyc + 3;
          exp_q.push_back(e);
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    last_exp = e;
    repeat (8) @(negedge clk);
    // R9: result holds after done
    check("R9 delay hold", int'(best_delay), e.dly);
    check("R9 lo hold", int'(bin_lo), e.lo);
    check("R9 hi hold", int'(bin_hi), e.hi);
    check("R9 score hold", int'(best_score), e.score);
    check("R7 done low after pulse", int'(done), 0);
  endtask

  // monitor: pops expected items when done appears
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R7 unexpected done actual=1 expected=0");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check("R7 done cycle", cyc, e.cyc);
        check("R5 best_delay", int'(best_delay), e.dly);
        check("R2 bin_lo", int'(bin_lo), e.lo);
        check("R2 bin_hi", int'(bin_hi), e.hi);
        check("R3 score", int'(best_score), e.score);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    x_in = '0; y_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 done", int'(done), 0);
    check("R1 best_delay", int'(best_delay), 0);
    check("R1 bin_lo", int'(bin_lo), 0);
    check("R1 bin_hi", int'(bin_hi), 0);
    check("R1 best_score", int'(best_score), 0);

    // R3 / R8: random frame, back to back delays
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < NE; k++) begin
        xs[d][k] = int'($urandom % 128); ys[d][k] = int'($urandom % 128);
      end
    run_frame(1'b0);

    // R2 / R5 / R6: all values equal -> score 0, delay 0, bins 0
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < NE; k++) begin
        xs[d][k] = 50; ys[d][k] = 50;
      end
    run_frame(1'b0);

    // R4: worst case score 254 in delay 5; R2 ties in peak position
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < NE; k++) begin
        xs[d][k] = int'($urandom % 60); ys[d][k] = int'($urandom % 60);
      end
    for (int k = 0; k < NE; k++) begin xs[5][k] = 0; ys[5][k] = 0; end
    xs[5][1] = 127; ys[5][6] = 127;
    xs[2][2] = 90; xs[2][6] = 90; ys[2][3] = 80; ys[2][5] = 80;
    run_frame(1'b1);

    // R5: identical delays tie -> earliest; R8 with valid gaps
    for (int k = 0; k < NE; k++) begin
      xs[0][k] = int'($urandom % 128); ys[0][k] = int'($urandom % 128);
    end
    for (int d = 1; d < ND; d++)
      for (int k = 0; k < NE; k++) begin
        xs[d][k] = xs[0][k]; ys[d][k] = ys[0][k];
      end
    run_frame(1'b1);

    // R5: later delay strictly larger wins
    for (int d = 0; d < ND; d++)
      for (int k = 0; k < NE; k++) begin
        xs[d][k] = 10; ys[d][k] = 10;
      end
    xs[3][4] = 40; ys[3][0] = 30;
    xs[7][2] = 70; ys[7][7] = 65;
    run_frame(1'b0);

    check("R7 all results seen", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule